// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block holds three reloading down-counters and one wide up-counter behind a small word-addressed register window. The two narrow channels and the one wide channel each count down on a tick strobe that the channel selects. When a channel passes through zero, it either reloads from its load register or wraps to all ones. The same event latches an interrupt that stays set until software writes the channel's clear register. Both tick strobes are clock enables produced elsewhere: a slow one for periodic interrupts and a fast one for fine timekeeping.

The wide counter counts up on the fast tick once software sets its enable flag. It has no interrupt. It is read in two words. A read of the low word captures the upper bits, so that a later read of the high word returns bits from the same instant. A typical start-up writes the control register with enable clear, then the reload value, then the control register with enable set.

Top module: `tmr_bank`

## Requirements
- R1: After reset every counter, load value, control register, interrupt and snapshot is zero, so every readable offset returns zero and `irq` is 3'b000.
- R2: A reloading channel decrements by one only on a cycle in which its enable (control bit 7) is set and its chosen tick is high. Control bit 3 = 1 selects `tick_slow`, and bit 3 = 0 selects `tick_fast`. The other tick has no effect.
- R3: A write of any data to a channel's clear register (channel offset 0x0C) drops that channel's interrupt on the next cycle. Otherwise a set interrupt stays set.
- R4: A write to a channel's load register (offset 0x00) sets both the load value and the current count on the next cycle. The data is truncated to the channel width, and offsets 0x00 and 0x04 read back the load value and the count with the unused upper bits zero.
- R5: With control bit 6 set (periodic), a tick taken at count zero loads the count from the load register and sets the channel's interrupt.
- R6: With control bit 6 clear, a tick taken at count zero wraps the count to all ones at the channel width and sets the channel's interrupt.
- R7: The control register (offset 0x08) keeps only bits 7, 6 and 3 and reads back the others as zero. The sequence control = 0x48, load, control = 0xC8 produces no counting until the last write.
- R8: Channel windows start at 0x00 (16-bit, `irq[0]`), 0x20 (16-bit, `irq[1]`) and 0x80 (32-bit, `irq[2]`). Each channel counts and interrupts independently of the others.
- R9: The 40-bit counter increments on each `tick_fast` while its enable is set. Bit 8 of a write to 0x64 sets or clears the enable. The counter ignores `tick_slow` and drives no interrupt. A read of 0x60 returns counter bits 31:0.
- R10: A read of 0x64 returns the enable in bit 8 and, in bits 7:0, counter bits 39:32 as captured by the most recent read strobe on 0x60. The capture is zero if no such read has occurred.
- R11: Reads of offsets outside the defined registers return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | Slow count strobe, one clock wide |
| tick_fast | input | 1 | Fast count strobe, one clock wide |
| bus_wr | input | 1 | Write strobe for `bus_addr`/`bus_wdata` |
| bus_rd | input | 1 | Read strobe; only used to capture the wide counter's upper bits |
| bus_addr | input | 8 | Byte address of the register, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 3 | Latched underflow interrupts, one per reloading channel |

## Verification
The embedded properties assume that a write strobe and a tick can arrive in the same cycle, with a load write taking priority over a tick. They also assume that the low-word read strobe is a single-cycle pulse, so the snapshot properties see one capture per read. The stimulus raises each tick for exactly one clock edge, except where the fast tick is held high to walk the wide counter across its 32-bit boundary. It never overlaps a clear with an underflow, so the expected interrupt state does not depend on which of the two wins. The boundary crossing of the wide counter is exercised on a second instance whose low word is 12 bits wide, which makes the carry into the high word reachable within a few thousand ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // register selector inside one reloading channel window (address bits 3:2)
   typedef enum logic [1:0] {
      REG_LOAD  = 2'd0,
      REG_VALUE = 2'd1,
      REG_CTRL  = 2'd2,
      REG_CLR   = 2'd3
   } reg_sel_e;

   // control word bit positions
   localparam int unsigned CTRL_EN_BIT  = 7;
   localparam int unsigned CTRL_PER_BIT = 6;
   localparam int unsigned CTRL_SRC_BIT = 3;
   // enable flag position in the wide counter's high word
   localparam int unsigned FREE_EN_BIT  = 8;

   localparam int unsigned NUM_RELOAD = 3;
   localparam logic [7:0] CH_BASE [NUM_RELOAD] = '{8'h00, 8'h20, 8'h80};
   localparam logic [7:0] FREE_LO_OFS = 8'h60;
   localparam logic [7:0] FREE_HI_OFS = 8'h64;

   typedef struct packed {
      logic en;
      logic periodic;
      logic src_slow;
   } ctrl_t;

endpackage

// File: rtl/tmr_reload_chan.sv
module tmr_reload_chan
   import tmr_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_slow,
   input  logic             tick_fast,
   input  logic             load_wr,
   input  logic             ctrl_wr,
   input  logic             clr_wr,
   input  logic [WIDTH-1:0] load_data,
   input  ctrl_t            ctrl_data,
   output logic [WIDTH-1:0] load_q,
   output logic [WIDTH-1:0] cnt_q,
   output ctrl_t            ctrl_q,
   output logic             irq_q
);

   logic             tick_hit;
   logic             underflow;
   logic [WIDTH-1:0] cnt_d;

   assign tick_hit  = ctrl_q.en & (ctrl_q.src_slow ? tick_slow : tick_fast);
   // a load write replaces the count, so it suppresses the underflow event
   assign underflow = tick_hit & ~load_wr & (cnt_q == '0);

   always_comb begin
      cnt_d = cnt_q;
      if (load_wr) begin
         cnt_d = load_data;
      end else if (tick_hit) begin
         if (cnt_q == '0) begin
            cnt_d = ctrl_q.periodic ? load_q : '1;
         end else begin
            cnt_d = cnt_q - WIDTH'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_q <= '0;
         cnt_q  <= '0;
         ctrl_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (load_wr) load_q <= load_data;
         if (ctrl_wr) ctrl_q <= ctrl_data;
         if (underflow)   irq_q <= 1'b1;
         else if (clr_wr) irq_q <= 1'b0;
      end
   end

   // R4: load write lands in the count one cycle later
   a_r4_load_now : assert property (@(posedge clk) disable iff (!rst_n)
      load_wr |=> (cnt_q == $past(load_data)));

   // R2: no selected tick and no load -> count holds
   a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_hit && !load_wr) |=> $stable(cnt_q));

   // R2: a selected tick on a nonzero count steps down by one
   a_r2_step : assert property (@(posedge clk) disable iff (!rst_n)
      (tick_hit && !load_wr && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - WIDTH'(1)));

   // R5: periodic underflow reloads and raises the interrupt
   a_r5_reload : assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && ctrl_q.periodic) |=> ((cnt_q == $past(load_q)) && irq_q));

   // R6: one-shot style underflow wraps to all ones and raises the interrupt
   a_r6_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !ctrl_q.periodic) |=> ((&cnt_q) && irq_q));

   // R3: clear with no competing underflow drops the interrupt
   a_r3_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !underflow) |=> !irq_q);

   // R3: a pending interrupt survives until cleared
   a_r3_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr_wr) |=> irq_q);

endmodule

// File: rtl/tmr_free_cnt.sv
module tmr_free_cnt #(
   parameter int unsigned FREE_W = 40,
   parameter int unsigned DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic                     en_wr,
   input  logic                     en_data,
   input  logic                     lo_rd,
   output logic [DATA_W-1:0]        cnt_lo,
   output logic                     en_q,
   output logic [FREE_W-DATA_W-1:0] hi_snap_q
);

   localparam int unsigned HI_W = FREE_W - DATA_W;

   logic [FREE_W-1:0] cnt_q;
   logic [HI_W-1:0]   cnt_hi;

   assign cnt_lo = cnt_q[DATA_W-1:0];
   assign cnt_hi = cnt_q[FREE_W-1:DATA_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         en_q      <= 1'b0;
         hi_snap_q <= '0;
      end else begin
         if (en_q && tick) cnt_q <= cnt_q + FREE_W'(1);
         if (en_wr) en_q <= en_data;
         if (lo_rd) hi_snap_q <= cnt_hi;
      end
   end

   // R9: enabled counter advances by one per fast tick
   a_r9_step : assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && tick) |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + FREE_W'(1)));

   // R9: without an enabled tick the counter holds
   a_r9_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !(en_q && tick) |=> $stable(cnt_lo) && $stable(cnt_hi));

   // R10: a low-word read captures the upper bits of that cycle
   a_r10_snap : assert property (@(posedge clk) disable iff (!rst_n)
      lo_rd |=> (hi_snap_q == $past(cnt_hi)));

   // R10: the capture holds between low-word reads
   a_r10_keep : assert property (@(posedge clk) disable iff (!rst_n)
      !lo_rd |=> $stable(hi_snap_q));

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NARROW_W = 16,
   parameter int unsigned WIDE_W   = 32,
   parameter int unsigned FREE_W   = 40
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_slow,
   input  logic                  tick_fast,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic [NUM_RELOAD-1:0] irq
);

   localparam int unsigned NCH  = NUM_RELOAD;
   localparam int unsigned HI_W = FREE_W - DATA_W;

   initial begin : p_param_chk
      assert (ADDR_W >= 8) else $error("tmr_bank: ADDR_W must be at least 8");
      assert (NARROW_W >= 1 && NARROW_W <= WIDE_W && WIDE_W <= DATA_W)
         else $error("tmr_bank: channel widths must fit the data word");
      assert (DATA_W > FREE_EN_BIT) else $error("tmr_bank: DATA_W too small for enable flag");
      assert (FREE_W > DATA_W && HI_W <= FREE_EN_BIT)
         else $error("tmr_bank: wide counter high part must be 1..8 bits");
   end

   reg_sel_e          reg_sel;
   logic              word_ok;
   logic [NCH-1:0]    ch_hit;
   logic              lo_hit;
   logic              hi_hit;
   ctrl_t             ctrl_wdata;

   logic [DATA_W-1:0] ch_load_rd [NCH];
   logic [DATA_W-1:0] ch_val_rd  [NCH];
   logic [DATA_W-1:0] ch_ctrl_rd [NCH];

   logic [DATA_W-1:0] free_lo;
   logic              free_en;
   logic [HI_W-1:0]   free_snap;
   logic [DATA_W-1:0] hi_word;

   assign reg_sel = reg_sel_e'(bus_addr[3:2]);
   assign word_ok = (bus_addr[1:0] == 2'b00);
   assign lo_hit  = (bus_addr == ADDR_W'(FREE_LO_OFS));
   assign hi_hit  = (bus_addr == ADDR_W'(FREE_HI_OFS));

   assign ctrl_wdata.en       = bus_wdata[CTRL_EN_BIT];
   assign ctrl_wdata.periodic = bus_wdata[CTRL_PER_BIT];
   assign ctrl_wdata.src_slow = bus_wdata[CTRL_SRC_BIT];

   // ---------------- reloading channels ----------------
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      // the last channel is the wide one, the others are narrow
      localparam int unsigned        CW   = (i == NCH - 1) ? WIDE_W : NARROW_W;
      localparam logic [ADDR_W-1:0]  BASE = ADDR_W'(CH_BASE[i]);

      logic [CW-1:0] load_q;
      logic [CW-1:0] cnt_q;
      ctrl_t         ctrl_q;
      logic          wr_here;

      assign ch_hit[i] = word_ok && (bus_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
      assign wr_here   = bus_wr && ch_hit[i];

      tmr_reload_chan #(
         .WIDTH (CW)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_slow (tick_slow),
         .tick_fast (tick_fast),
         .load_wr   (wr_here && (reg_sel == REG_LOAD)),
         .ctrl_wr   (wr_here && (reg_sel == REG_CTRL)),
         .clr_wr    (wr_here && (reg_sel == REG_CLR)),
         .load_data (bus_wdata[CW-1:0]),
         .ctrl_data (ctrl_wdata),
         .load_q    (load_q),
         .cnt_q     (cnt_q),
         .ctrl_q    (ctrl_q),
         .irq_q     (irq[i])
      );

      if (CW == DATA_W) begin : g_full
         assign ch_load_rd[i] = load_q;
         assign ch_val_rd[i]  = cnt_q;
      end else begin : g_pad
         assign ch_load_rd[i] = {{(DATA_W - CW){1'b0}}, load_q};
         assign ch_val_rd[i]  = {{(DATA_W - CW){1'b0}}, cnt_q};
      end

      always_comb begin
         ch_ctrl_rd[i]               = '0;
         ch_ctrl_rd[i][CTRL_EN_BIT]  = ctrl_q.en;
         ch_ctrl_rd[i][CTRL_PER_BIT] = ctrl_q.periodic;
         ch_ctrl_rd[i][CTRL_SRC_BIT] = ctrl_q.src_slow;
      end
   end

   // ---------------- wide free-running counter ----------------
   tmr_free_cnt #(
      .FREE_W (FREE_W),
      .DATA_W (DATA_W)
   ) u_free (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_fast),
      .en_wr     (bus_wr && hi_hit),
      .en_data   (bus_wdata[FREE_EN_BIT]),
      .lo_rd     (bus_rd && lo_hit),
      .cnt_lo    (free_lo),
      .en_q      (free_en),
      .hi_snap_q (free_snap)
   );

   always_comb begin
      hi_word              = '0;
      hi_word[HI_W-1:0]    = free_snap;
      hi_word[FREE_EN_BIT] = free_en;
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (ch_hit[i]) begin
            unique case (reg_sel)
               REG_LOAD:  bus_rdata = ch_load_rd[i];
               REG_VALUE: bus_rdata = ch_val_rd[i];
               REG_CTRL:  bus_rdata = ch_ctrl_rd[i];
               REG_CLR:   bus_rdata = '0;
            endcase
         end
      end
      if (lo_hit) bus_rdata = free_lo;
      if (hi_hit) bus_rdata = hi_word;
   end

   // R8: the channel windows never overlap each other or the wide counter
   a_r8_one_window : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ch_hit, lo_hit, hi_hit}));

endmodule

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;

   localparam logic [2:0] OP_WR = 3'd0;
   localparam logic [2:0] OP_RD = 3'd1;
   localparam logic [2:0] OP_TS = 3'd2;
   localparam logic [2:0] OP_TF = 3'd3;
   localparam logic [2:0] OP_IQ = 3'd4;

   typedef struct packed {
      logic [2:0]  op;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 63;
   localparam vec_t VECS [NV] = '{
      '{OP_RD, 8'h04, 32'h0, 32'h0, 8'd1},        // R1 count zero
      '{OP_RD, 8'h08, 32'h0, 32'h0, 8'd1},        // R1 control zero
      '{OP_IQ, 8'h00, 32'h0, 32'h0, 8'd1},        // R1 no irq
      '{OP_WR, 8'h08, 32'h48, 32'h0, 8'd7},       // R7 control, enable off
      '{OP_RD, 8'h08, 32'h0, 32'h48, 8'd7},       // R7 readback
      '{OP_WR, 8'h00, 32'h3, 32'h0, 8'd4},        // R4 load 3
      '{OP_RD, 8'h04, 32'h0, 32'h3, 8'd4},        // R4 count = 3
      '{OP_TS, 8'h00, 32'd2, 32'h0, 8'd7},        // R7 ticks before enable
      '{OP_RD, 8'h04, 32'h0, 32'h3, 8'd7},        // R7 no counting yet
      '{OP_WR, 8'h08, 32'hC8, 32'h0, 8'd7},       // R7 final enable write
      '{OP_TS, 8'h00, 32'd1, 32'h0, 8'd2},
      '{OP_RD, 8'h04, 32'h0, 32'h2, 8'd2},        // R2 one step
      '{OP_TF, 8'h00, 32'd3, 32'h0, 8'd2},        // R2 unselected tick
      '{OP_RD, 8'h04, 32'h0, 32'h2, 8'd2},
      '{OP_TS, 8'h00, 32'd2, 32'h0, 8'd2},
      '{OP_RD, 8'h04, 32'h0, 32'h0, 8'd2},        // R2 reached zero
      '{OP_IQ, 8'h00, 32'h0, 32'h0, 8'd5},        // R5 zero is not underflow
      '{OP_TS, 8'h00, 32'd1, 32'h0, 8'd5},
      '{OP_RD, 8'h04, 32'h0, 32'h3, 8'd5},        // R5 reload
      '{OP_IQ, 8'h00, 32'h0, 32'h1, 8'd5},        // R5 irq[0]
      '{OP_TS, 8'h00, 32'd1, 32'h0, 8'd3},
      '{OP_IQ, 8'h00, 32'h0, 32'h1, 8'd3},        // R3 sticky
      '{OP_WR, 8'h0C, 32'h0, 32'h0, 8'd3},        // R3 clear
      '{OP_IQ, 8'h00, 32'h0, 32'h0, 8'd3},
      '{OP_WR, 8'h20, 32'h1, 32'h0, 8'd8},        // R8 ch2 load 1
      '{OP_WR, 8'h28, 32'h80, 32'h0, 8'd6},       // R6 enable, wrap, fast
      '{OP_TF, 8'h00, 32'd2, 32'h0, 8'd6},
      '{OP_RD, 8'h24, 32'h0, 32'h0000FFFF, 8'd6}, // R6 wrap to all ones
      '{OP_IQ, 8'h00, 32'h0, 32'h2, 8'd8},        // R8 irq[1] only
      '{OP_TS, 8'h00, 32'd1, 32'h0, 8'd2},
      '{OP_RD, 8'h24, 32'h0, 32'h0000FFFF, 8'd2}, // R2 ch2 ignores slow
      '{OP_RD, 8'h04, 32'h0, 32'h1, 8'd8},        // R8 ch1 independent
      '{OP_WR, 8'h2C, 32'hDEAD, 32'h0, 8'd3},     // R3 clear any data
      '{OP_IQ, 8'h00, 32'h0, 32'h0, 8'd3},
      '{OP_WR, 8'h80, 32'h00012345, 32'h0, 8'd4},
      '{OP_RD, 8'h84, 32'h0, 32'h00012345, 8'd4}, // R4 wide load
      '{OP_WR, 8'h00, 32'hABCD1234, 32'h0, 8'd4},
      '{OP_RD, 8'h04, 32'h0, 32'h00001234, 8'd4}, // R4 truncated count
      '{OP_RD, 8'h00, 32'h0, 32'h00001234, 8'd4}, // R4 truncated load
      '{OP_WR, 8'h88, 32'hFFFFFFFF, 32'h0, 8'd7},
      '{OP_RD, 8'h88, 32'h0, 32'hC8, 8'd7},       // R7 masked control
      '{OP_TS, 8'h00, 32'd1, 32'h0, 8'd8},
      '{OP_RD, 8'h84, 32'h0, 32'h00012344, 8'd8}, // R8 ch3 counts
      '{OP_RD, 8'h04, 32'h0, 32'h00001233, 8'd8},
      '{OP_WR, 8'h40, 32'h5555, 32'h0, 8'd11},    // R11 undefined write
      '{OP_RD, 8'h40, 32'h0, 32'h0, 8'd11},       // R11 reads zero
      '{OP_RD, 8'h10, 32'h0, 32'h0, 8'd11},
      '{OP_RD, 8'h04, 32'h0, 32'h00001233, 8'd11},// R11 no side effect
      '{OP_RD, 8'h60, 32'h0, 32'h0, 8'd9},        // R9 idle wide counter
      '{OP_RD, 8'h64, 32'h0, 32'h0, 8'd10},       // R10 high word zero
      '{OP_WR, 8'h64, 32'h100, 32'h0, 8'd9},      // R9 enable
      '{OP_RD, 8'h64, 32'h0, 32'h100, 8'd10},     // R10 enable flag
      '{OP_TF, 8'h00, 32'd5, 32'h0, 8'd9},
      '{OP_RD, 8'h60, 32'h0, 32'h5, 8'd9},        // R9 five ticks
      '{OP_TS, 8'h00, 32'd3, 32'h0, 8'd9},
      '{OP_RD, 8'h60, 32'h0, 32'h5, 8'd9},        // R9 ignores slow tick
      '{OP_IQ, 8'h00, 32'h0, 32'h0, 8'd9},        // R9 no interrupt
      '{OP_RD, 8'h84, 32'h0, 32'h00012341, 8'd8},
      '{OP_WR, 8'h80, 32'h1, 32'h0, 8'd8},
      '{OP_TS, 8'h00, 32'd2, 32'h0, 8'd8},
      '{OP_IQ, 8'h00, 32'h0, 32'h4, 8'd8},        // R8 irq[2] only
      '{OP_RD, 8'h04, 32'h0, 32'h0000122E, 8'd8},
      '{OP_RD, 8'h24, 32'h0, 32'h0000FFFA, 8'd2}  // R2 ch2 fast ticks
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_slow = 1'b0;
   logic        tick_fast = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq;

   // narrow instance: 12-bit data word, 20-bit wide counter
   logic        s_tick = 1'b0;
   logic        s_wr = 1'b0;
   logic        s_rd = 1'b0;
   logic [7:0]  s_addr = '0;
   logic [11:0] s_wdata = '0;
   logic [11:0] s_rdata;
   logic [2:0]  s_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   tmr_bank u_dut (
      .clk (clk), .rst_n (rst_n), .tick_slow (tick_slow), .tick_fast (tick_fast),
      .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
   );

   tmr_bank #(
      .ADDR_W (8), .DATA_W (12), .NARROW_W (8), .WIDE_W (12), .FREE_W (20)
   ) u_small (
      .clk (clk), .rst_n (rst_n), .tick_slow (1'b0), .tick_fast (s_tick),
      .bus_wr (s_wr), .bus_rd (s_rd), .bus_addr (s_addr),
      .bus_wdata (s_wdata), .bus_rdata (s_rdata), .irq (s_irq)
   );

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(posedge clk);
      #1 bus_rd = 1'b0;
   endtask

   task automatic pulse_ticks(input bit slow, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
         @(posedge clk);
         #1 tick_slow = 1'b0; tick_fast = 1'b0;
      end
   endtask

   task automatic s_read(input logic [7:0] a, output logic [11:0] d);
      @(negedge clk);
      s_addr = a; s_rd = 1'b1;
      #2 d = s_rdata;
      @(posedge clk);
      #1 s_rd = 1'b0;
   endtask

   task automatic s_hold_tick(input int n);
      @(negedge clk);
      s_tick = 1'b1;
      repeat (n) @(negedge clk);
      s_tick = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin : stim
      logic [31:0] rd;
      logic [11:0] srd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // vector table
      for (int k = 0; k < NV; k++) begin
         case (VECS[k].op)
            OP_WR: bus_write(VECS[k].addr, VECS[k].data);
            OP_RD: begin
               bus_read(VECS[k].addr, rd);
               check(int'(VECS[k].req), rd, VECS[k].exp, $sformatf("vec %0d read", k));
            end
            OP_TS: pulse_ticks(1'b1, int'(VECS[k].data));
            OP_TF: pulse_ticks(1'b0, int'(VECS[k].data));
            default: begin
               @(negedge clk);
               check(int'(VECS[k].req), {29'd0, irq}, VECS[k].exp, $sformatf("vec %0d irq", k));
            end
         endcase
      end

      // R10: carry into the high word, on the narrow instance (low word 12 bits)
      @(negedge clk);
      s_addr = 8'h64; s_wdata = 12'h100; s_wr = 1'b1;
      @(posedge clk);
      #1 s_wr = 1'b0;
      s_hold_tick(4100);                   // count 0x01004
      s_read(8'h64, srd);
      check(10, {20'd0, srd}, 32'h100, "high word before any low read");
      s_read(8'h60, srd);
      check(9, {20'd0, srd}, 32'h004, "narrow low word");
      s_read(8'h64, srd);
      check(10, {20'd0, srd}, 32'h101, "high word after low read");
      s_hold_tick(4096);                   // count 0x02004
      s_read(8'h64, srd);
      check(10, {20'd0, srd}, 32'h101, "high word keeps snapshot");
      s_read(8'h60, srd);
      check(10, {20'd0, srd}, 32'h004, "low word after second carry");
      s_read(8'h64, srd);
      check(10, {20'd0, srd}, 32'h102, "high word new snapshot");
      @(negedge clk);
      check(9, {29'd0, s_irq}, 32'h0, "wide counter raises no irq");

      // R1: reset while an interrupt is pending
      @(negedge clk);
      check(1, {29'd0, irq}, 32'h4, "irq pending before reset");
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, {29'd0, irq}, 32'h0, "irq after reset");
      bus_read(8'h84, rd);
      check(1, rd, 32'h0, "ch3 count after reset");
      bus_read(8'h64, rd);
      check(1, rd, 32'h0, "wide high word after reset");
      bus_read(8'h60, rd);
      check(1, rd, 32'h0, "wide low word after reset");
      bus_read(8'h28, rd);
      check(1, rd, 32'h0, "ch2 control after reset");

      finish_run();
   end

endmodule